// File: doc/BRIEF.md
# Seconds-Based System Watchdog

This block is a bus-mapped watchdog timer that counts whole seconds. It has a control word and a count word. Software loads a reload value, in seconds, into the count word. It then enables the timer and, with a later and separate control write, kicks it. A kick copies the reload value into the down-counter. Each pulse on the one-second strobe input takes one from the counter while the timer runs. If software stops kicking and the counter runs out, the block raises a one-cycle request on one of two outputs. The action bit picks the output: a system reset request or a power-off request.

On expiry the block also sets a sticky fired flag. This flag has its own power-on reset, so the system reset that the expiry causes leaves it in place. Boot software can read it to find out why the system restarted. A strap input marks the watchdog hardware as unavailable. While the strap is set, the block ignores start and kick writes.

The bus is a single-cycle interface: a write takes effect at the clock edge where it is presented, and read data is combinational from the address. This port is the only access to the timer; the block has no other bus logic around it.

Top module: `sec_watchdog`

## Requirements
- R1: After the synchronous reset `rst_n`, the control word reads 0 (the fired flag aside) and the count word reads 0. The reload value resets to `DEF_TIMEOUT` seconds, which a kick after start loads.
- R2: A write to the count word (byte offset 4) stores its low `CNT_W` bits as the reload value and ignores the upper bits. A stored value of 0 becomes 1, so the range is 1 to 2^`CNT_W`-1.
- R3: A read of the count word returns the seconds left, zero-extended. While the timer runs, each clock cycle with `tick_1s` high lowers it by one.
- R4: Control word (byte offset 0) bit 0 is the start bit. While it is 0 the count holds and no request is ever raised.
- R5: Writing 1 to control bit 7 (the kick bit) loads the reload value into the counter, but only if the start bit was already 1 before that write. A kick in the same write that sets start does nothing. Bit 7 always reads 0, and a kick that coincides with a tick takes priority over the tick.
- R6: A count-word write while the timer runs leaves the seconds left unchanged until the next kick.
- R7: When a tick takes the count from 1 to 0, one output pulses high for exactly one clock cycle. It is `sys_rst_req` if control bit 1 (action) is 0 and `pwr_off_req` if it is 1. Afterwards the count stays at 0 and the start bit stays 1.
- R8: Control bit 8 (fired) is set by an expiry. It holds through `rst_n`, and `por_n` or any control-word write clears it. An expiry in the same cycle as that write wins.
- R9: Control bit 2 (read-only) reflects `hw_off`. While it is 1, writes can neither set the start bit nor kick.
- R10: Reads of any other offset return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset, including resets the watchdog itself caused |
| por_n | input | 1 | Synchronous active-low power-on reset, the only clear besides software for the fired flag |
| tick_1s | input | 1 | One-cycle strobe, once per second |
| hw_off | input | 1 | Strap: watchdog hardware unavailable |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| sys_rst_req | output | 1 | One-cycle system reset request on expiry |
| pwr_off_req | output | 1 | One-cycle power-off request on expiry |

## Verification
The bench builds the block with its default 16-bit counter and a 60-second reset reload value, so R1 is checked at its real value. It sweeps every reload value from 1 to 8 with both action settings and checks the count after each tick, which brings every expiry edge within reach in a few hundred cycles. It also checks the all-ones reload value and the clamp of zero to one at the ends of the range.

// File: rtl/swd_pkg.sv
// Shared offsets and bit positions for the seconds watchdog.
// Assumes byte-addressed 32-bit words; only the offsets below decode.
package swd_pkg;
    localparam int OFS_CTRL  = 0;
    localparam int OFS_COUNT = 4;
    localparam int B_RUN     = 0;
    localparam int B_ACTION  = 1;
    localparam int B_OFF     = 2;
    localparam int B_KICK    = 7;
    localparam int B_FIRED   = 8;

    // Expiry action encoding held in the action bit.
    typedef enum logic {
        ACT_RESET    = 1'b0,
        ACT_POWEROFF = 1'b1
    } action_e;
endpackage

// File: rtl/swd_regs.sv
// Register file and decode for the watchdog.
// Holds start/action/reload/fired state, produces the kick strobe.
// Assumes single-cycle bus: writes act at the edge they are presented.
module swd_regs
    import swd_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int CNT_W       = 16,
    parameter int DEF_TIMEOUT = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hw_off,
    input  logic              expire,
    input  logic [CNT_W-1:0]  remaining,
    output logic              run,
    output action_e           action,
    output logic              reload,
    output logic [CNT_W-1:0]  timeout,
    output logic              fired,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [CNT_W-1:0] DEF_VAL = CNT_W'(DEF_TIMEOUT);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic ctrl_wr, count_wr, ctrl_rd_sel, count_rd_sel;
    logic [CNT_W-1:0] wr_cnt;

    // Address decode for the two words.
    always_comb begin
        ctrl_rd_sel  = (bus_addr == ADDR_W'(OFS_CTRL));
        count_rd_sel = (bus_addr == ADDR_W'(OFS_COUNT));
        ctrl_wr      = bus_sel && bus_we && ctrl_rd_sel;
        count_wr     = bus_sel && bus_we && count_rd_sel;
        wr_cnt       = bus_wdata[CNT_W-1:0];
    end

    // Kick only counts when start was set before this write.
    assign reload = ctrl_wr && bus_wdata[B_KICK] && run && !hw_off;

    // Start and action bits; start cannot be set while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            action <= ACT_RESET;
        end else if (ctrl_wr) begin
            action <= action_e'(bus_wdata[B_ACTION]);
            if (!(hw_off && bus_wdata[B_RUN])) run <= bus_wdata[B_RUN];
        end
    end

    // Reload value; zero is clamped to one second.
    always_ff @(posedge clk) begin
        if (!rst_n)        timeout <= DEF_VAL;
        else if (count_wr) timeout <= (wr_cnt == '0) ? ONE : wr_cnt;
    end

    // Sticky fired flag on the power-on reset only.
    always_ff @(posedge clk) begin
        if (!por_n)       fired <= 1'b0;
        else if (expire)  fired <= 1'b1;
        else if (ctrl_wr) fired <= 1'b0;
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_rd_sel) begin
            bus_rdata[B_RUN]    = run;
            bus_rdata[B_ACTION] = action;
            bus_rdata[B_OFF]    = hw_off;
            bus_rdata[B_FIRED]  = fired;
        end else if (count_rd_sel) begin
            bus_rdata[CNT_W-1:0] = remaining;
        end
    end

    p_no_zero_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        timeout != '0);
    p_off_blocks_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_off && !run) |=> !run);
endmodule

// File: rtl/swd_countdown.sv
// Seconds down-counter with expiry pulse generation.
// Assumes tick_1s is a one-cycle strobe; reload takes priority over tick.
module swd_countdown
    import swd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1s,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] timeout,
    input  action_e          action,
    output logic [CNT_W-1:0] remaining,
    output logic             expire,
    output logic             sys_rst_req,
    output logic             pwr_off_req
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    // A tick advances only a running, non-exhausted, un-kicked counter.
    always_comb begin
        step   = rst_n && run && tick_1s && !reload && (remaining != '0);
        expire = step && (remaining == ONE);
    end

    // Counter update.
    always_ff @(posedge clk) begin
        if (!rst_n)      remaining <= '0;
        else if (reload) remaining <= timeout;
        else if (step)   remaining <= remaining - ONE;
    end

    // Registered one-cycle request on the selected output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst_req <= 1'b0;
            pwr_off_req <= 1'b0;
        end else begin
            sys_rst_req <= expire && (action == ACT_RESET);
            pwr_off_req <= expire && (action == ACT_POWEROFF);
        end
    end

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1s && !reload) |=> $stable(remaining));
    p_stopped_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> !(sys_rst_req || pwr_off_req));
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req || pwr_off_req) |=> !(sys_rst_req || pwr_off_req));
    p_req_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req || pwr_off_req) |-> (remaining == '0));
endmodule

// File: rtl/sec_watchdog.sv
// Top of the seconds watchdog: register file plus down-counter.
// Assumes rst_n may be driven by this block's own reset request; por_n is not.
module sec_watchdog
    import swd_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int CNT_W       = 16,
    parameter int DEF_TIMEOUT = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              tick_1s,
    input  logic              hw_off,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_req,
    output logic              pwr_off_req
);
    logic             run, reload, expire, fired;
    action_e          action;
    logic [CNT_W-1:0] timeout, remaining;

    swd_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .hw_off(hw_off), .expire(expire), .remaining(remaining),
        .run(run), .action(action), .reload(reload), .timeout(timeout),
        .fired(fired), .bus_rdata(bus_rdata)
    );

    swd_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .run(run), .reload(reload),
        .timeout(timeout), .action(action), .remaining(remaining), .expire(expire),
        .sys_rst_req(sys_rst_req), .pwr_off_req(pwr_off_req)
    );

    p_fired_on_req_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (sys_rst_req || pwr_off_req) |-> fired);
    p_req_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys_rst_req && pwr_off_req));
endmodule

// File: tb/test_sec_watchdog.sv
module test_sec_watchdog;
    localparam int DW = 32;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_n = 1'b0, tick_1s = 1'b0, hw_off = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic sys_rst_req, pwr_off_req;

    int checks = 0, errors = 0;
    logic seen_rst, seen_pwr;
    logic [DW-1:0] rv;

    sec_watchdog #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(16), .DEF_TIMEOUT(60)) i_sec_watchdog (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_1s(tick_1s), .hw_off(hw_off),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req), .pwr_off_req(pwr_off_req)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // One tick; records which request is high after the edge it is sampled on.
    task automatic tick();
        @(negedge clk);
        tick_1s = 1'b1;
        @(posedge clk);
        #1 seen_rst = sys_rst_req; seen_pwr = pwr_off_req;
        @(negedge clk);
        tick_1s = 1'b0;
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;

        // R1 reset state
        rd(0, rv); chk("R1 ctrl", rv, 32'h0);
        rd(4, rv); chk("R1 count", rv, 32'h0);
        wr(0, 32'h1); wr(0, 32'h81);
        rd(4, rv); chk("R1 default reload 60", rv, 32'd60);
        rd(0, rv); chk("R5 kick reads 0", rv, 32'h1);

        // R10 unmapped offsets
        wr(8, 32'hFFFF_FFFF);
        rd(8, rv); chk("R10 unmapped read", rv, 32'h0);
        rd(0, rv); chk("R10 ctrl unchanged", rv, 32'h1);
        rd(4, rv); chk("R10 count unchanged", rv, 32'd60);

        // R2 upper bits ignored, zero clamps to one
        wr(4, 32'hABCD_0003); wr(0, 32'h81);
        rd(4, rv); chk("R2 low bits", rv, 32'd3);
        wr(4, 32'h0001_0000); wr(0, 32'h81);
        rd(4, rv); chk("R2 zero clamp", rv, 32'd1);
        wr(4, 32'h0000_FFFF); wr(0, 32'h81);
        rd(4, rv); chk("R2 max", rv, 32'hFFFF);

        // R4 stop holds count, no request
        wr(0, 32'h0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R4 no request when stopped", {30'b0, seen_rst, seen_pwr}, 32'h0);
        end
        rd(4, rv); chk("R4 count held", rv, 32'hFFFF);
        wr(4, 32'd1); wr(0, 32'h1); tick();
        chk("R4 running at max then", {30'b0, seen_rst, seen_pwr}, 32'h0);
        rd(4, rv); chk("R3 one tick", rv, 32'hFFFE);

        // R5 kick in same write as start does nothing
        sys_reset();
        wr(4, 32'd5); wr(0, 32'h81);
        rd(4, rv); chk("R5 same-write kick", rv, 32'h0);
        rd(0, rv); chk("R5 start set", rv, 32'h1);

        // R6 count write while running changes only the reload value
        wr(0, 32'h81); tick();
        wr(4, 32'd9);
        rd(4, rv); chk("R6 remaining kept", rv, 32'd4);
        wr(0, 32'h81);
        rd(4, rv); chk("R6 new value on kick", rv, 32'd9);

        // R5 kick coincides with tick: kick wins
        @(negedge clk);
        tick_1s = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h81;
        @(negedge clk);
        tick_1s = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        rd(4, rv); chk("R5 kick over tick", rv, 32'd9);

        // R3 R7 R8 sweep of reload values and both actions
        for (int t = 1; t <= 8; t++) begin
            for (int a = 0; a < 2; a++) begin
                logic [DW-1:0] cw;
                cw = {30'b0, a[0], 1'b1};
                wr(0, 32'h0);
                wr(4, t);
                wr(0, cw); wr(0, cw | 32'h80);
                rd(4, rv); chk("R3 loaded", rv, t);
                for (int k = 1; k <= t; k++) begin
                    tick();
                    chk("R7 request lines", {30'b0, seen_rst, seen_pwr},
                        (k == t) ? (a == 0 ? 32'h2 : 32'h1) : 32'h0);
                    rd(4, rv); chk("R3 seconds left", rv, t - k);
                end
                tick();
                chk("R7 single pulse", {30'b0, seen_rst, seen_pwr}, 32'h0);
                rd(4, rv); chk("R7 stays zero", rv, 32'h0);
                rd(0, rv); chk("R8 fired and start kept", rv, 32'h100 | cw);
            end
        end

        // R8 fired survives system reset, cleared by control write
        sys_reset();
        rd(0, rv); chk("R8 fired through rst_n", rv, 32'h100);
        rd(4, rv); chk("R1 count after rst_n", rv, 32'h0);
        wr(0, 32'h2);
        rd(0, rv); chk("R8 cleared by ctrl write", rv, 32'h2);

        // R8 por_n clears fired
        wr(4, 32'd1); wr(0, 32'h1); wr(0, 32'h81); tick();
        rd(0, rv); chk("R8 set again", rv, 32'h101);
        @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        rd(0, rv); chk("R8 cleared by por_n", rv, 32'h1);

        // R9 disabled strap
        sys_reset();
        hw_off = 1'b1;
        wr(0, 32'h1);
        rd(0, rv); chk("R9 start ignored", rv, 32'h4);
        hw_off = 1'b0;
        wr(4, 32'd6); wr(0, 32'h1); wr(0, 32'h81); tick();
        hw_off = 1'b1;
        wr(0, 32'h81);
        rd(4, rv); chk("R9 kick ignored", rv, 32'd5);
        rd(0, rv); chk("R9 status bit", rv, 32'h5);
        hw_off = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule